// File: doc/BRIEF.md
# Per-Pin Edge Event Extractor

This block sits behind a two-channel change interrupt and converts each per-channel change indication into per-pin edge events. For every pin it stores a pin enable, a rising-edge select and a falling-edge select. For every channel it keeps a snapshot of the pin data as it stood at that channel's last evaluation. When a channel has a pending change and its channel enable is set, the block compares the live data with the snapshot, reports the qualifying rising and falling edges as one event vector, and replaces the snapshot with the live data.

Pins are numbered globally. Channel 1 holds indices 0 to W1-1 and channel 2 holds W1 to W1+W2-1. Trigger types are written one pin at a time through a command port that carries a global pin index and a 2-bit type code. Pin enables are written the same way. The channel enable follows from the pin enables: it rises when the first pin of a channel is enabled and falls when the last one is cleared. Enabling the first pin also discards any stale change status for that channel and reloads its snapshot, so edges that happened while the channel was off are never reported.

Events leave on a valid/ready stream. Each beat carries one channel's events at their global bit positions, together with the channel number. Once a beat is presented, it holds with `ev_vec` and `ev_chan` unchanged until `ev_ready` is high at a clock edge. While a beat is stalled, no evaluation takes place. Change indications that arrive during a stall stay pending, and the data is sampled only when the stall ends.

Top module: `pin_edge_events`

## Requirements
- R1: A pin reports a rising event when its live data is 1, its snapshot bit is 0, its pin enable is set, and its rising select is set.
- R2: A pin reports a falling event when its live data is 0, its snapshot bit is 1, its pin enable is set, and its falling select is set.
- R3: A beat carries the OR of the rising and falling events of one channel. Each evaluation copies that channel's live data into its snapshot. Data changes between evaluations are not events in themselves.
- R4: Trigger type code 2'b01 selects rising only, 2'b10 falling only, and 2'b11 both edges. Code 2'b00 (level-sensitive) is rejected: `cfg_err` is high for exactly the cycle after the command, and that pin's selects keep their values.
- R5: Enabling a pin in a channel whose pin enables are all zero does three things: it clears that channel's pending change, reloads that channel's snapshot from live data, and sets `ch_en` for that channel from the next cycle.
- R6: Clearing a pin enable that leaves its channel with no enabled pin clears that channel's `ch_en` from the next cycle. Clearing a pin while other pins of the channel remain enabled leaves `ch_en` set.
- R7: Channel 2 local pin k has global index W1+k in both the commands and `ev_vec`. Commands naming an index of W1+W2 or above have no effect.
- R8: Only a channel that is both pending and enabled is evaluated. When both channels qualify, channel 1 is evaluated first and channel 2 at the next opportunity. A `chg` bit latches as pending whether or not the channel is enabled.
- R9: `ev_valid` together with stable `ev_vec` and `ev_chan` holds until `ev_ready` is high at an edge. While a beat is held, no evaluation takes place.
- R10: An evaluation that yields no event clears the pending change and updates the snapshot, but presents no beat.
- R11: After reset, all enables, selects, snapshots and pending flags are zero, and `ev_valid`, `ch_en` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Trigger-type command strobe |
| cfg_pin | input | $clog2(W1+W2) | Global pin index for the trigger command |
| cfg_type | input | 2 | Trigger code: 01 rise, 10 fall, 11 both, 00 rejected |
| cfg_err | output | 1 | One-cycle flag for a rejected trigger code |
| en_valid | input | 1 | Pin-enable command strobe |
| en_pin | input | $clog2(W1+W2) | Global pin index for the enable command |
| en_set | input | 1 | 1 enables the pin, 0 disables it |
| ch1_data | input | W1 | Live data of channel 1 |
| ch2_data | input | W2 | Live data of channel 2 |
| chg | input | 2 | Per-channel change indication, bit 0 for channel 1 |
| ch_en | output | 2 | Channel-level enable, bit 0 for channel 1 |
| ev_valid | output | 1 | Event beat valid |
| ev_ready | input | 1 | Consumer accepts the beat |
| ev_vec | output | W1+W2 | Event bits at global pin positions |
| ev_chan | output | 1 | Channel of the beat: 0 for channel 1, 1 for channel 2 |

## Verification
The bench first checks that the edge reference is the snapshot and not the previous cycle. It toggles a pin twice between change indications and expects silence; a design that used a one-cycle delay register would report phantom edges. It also changes data while a channel is disabled and then re-enables it. A design that kept the stale pending flag or skipped the snapshot reload would report edges that happened while the channel was off. It raises both channels at once to catch a wrong evaluation order or a channel 2 offset error in `ev_vec`. It stalls `ev_ready` to expose a beat that changes or is dropped while held, and it sends a level code on a configured pin to show that a rejection does not corrupt the existing selects.

// File: rtl/edge_evt_pkg.sv
package edge_evt_pkg;
  typedef enum logic [1:0] {
    TRG_LEVEL = 2'b00,
    TRG_RISE  = 2'b01,
    TRG_FALL  = 2'b10,
    TRG_BOTH  = 2'b11
  } trig_e;
endpackage

// File: rtl/eev_trig_cfg.sv
module eev_trig_cfg
  import edge_evt_pkg::*;
#(
  parameter int NP = 12,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [IW-1:0] cfg_pin,
  input  logic [1:0]    cfg_type,
  output logic          cfg_err,
  output logic [NP-1:0] rise_sel,
  output logic [NP-1:0] fall_sel
);
  logic in_range;
  assign in_range = int'(cfg_pin) < NP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_sel <= '0;
      fall_sel <= '0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= cfg_valid && (trig_e'(cfg_type) == TRG_LEVEL);
      if (cfg_valid && in_range) begin
        case (trig_e'(cfg_type))
          TRG_RISE: begin rise_sel[cfg_pin] <= 1'b1; fall_sel[cfg_pin] <= 1'b0; end
          TRG_FALL: begin rise_sel[cfg_pin] <= 1'b0; fall_sel[cfg_pin] <= 1'b1; end
          TRG_BOTH: begin rise_sel[cfg_pin] <= 1'b1; fall_sel[cfg_pin] <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  // R4: a level code raises the error flag and leaves the selects untouched
  p_level_rejected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_type == 2'b00) |=> (cfg_err && $stable(rise_sel) && $stable(fall_sel)));
endmodule

// File: rtl/eev_pin_enable.sv
module eev_pin_enable #(
  parameter int W1 = 5,
  parameter int W2 = 7,
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_valid,
  input  logic [IW-1:0]    en_pin,
  input  logic             en_set,
  output logic [W1+W2-1:0] en_mask,
  output logic [1:0]       ch_en,
  output logic [1:0]       arm
);
  localparam int NP = W1 + W2;

  logic          hit;
  logic [NP-1:0] mask_nx;
  logic [1:0]    ch_nx;

  always_comb begin
    hit     = en_valid && (int'(en_pin) < NP);
    mask_nx = en_mask;
    if (hit) mask_nx[en_pin] = en_set;
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam int LO = (c == 0) ? 0 : W1;
    localparam int WD = (c == 0) ? W1 : W2;
    logic in_ch;
    assign in_ch    = hit && (int'(en_pin) >= LO) && (int'(en_pin) < LO + WD);
    assign arm[c]   = in_ch && en_set && (en_mask[LO +: WD] == '0);
    assign ch_nx[c] = |mask_nx[LO +: WD];

    // R5: first pin enabled in an idle channel turns the channel on
    p_arm_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arm[c] |=> ch_en[c]);
    // R6: channel enable mirrors whether any of its pins is enabled
    p_chen_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ch_en[c] == (|en_mask[LO +: WD]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask <= '0;
      ch_en   <= '0;
    end else begin
      en_mask <= mask_nx;
      ch_en   <= ch_nx;
    end
  end
endmodule

// File: rtl/eev_evaluator.sv
module eev_evaluator #(
  parameter int W1 = 5,
  parameter int W2 = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W1+W2-1:0] data,
  input  logic [1:0]       chg,
  input  logic [1:0]       ch_en,
  input  logic [1:0]       arm,
  input  logic [W1+W2-1:0] en_mask,
  input  logic [W1+W2-1:0] rise_sel,
  input  logic [W1+W2-1:0] fall_sel,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [W1+W2-1:0] ev_vec,
  output logic             ev_chan
);
  localparam int NP = W1 + W2;
  localparam logic [NP-1:0] M0 = {{W2{1'b0}}, {W1{1'b1}}};
  localparam logic [NP-1:0] M1 = ~M0;

  logic [1:0]    pend, pend_nx;
  logic [NP-1:0] snap, snap_nx;
  logic          can, go, sel;
  logic [NP-1:0] cmask, rise_ev, fall_ev, evs;

  always_comb begin
    can     = !ev_valid || ev_ready;
    sel     = !(pend[0] && ch_en[0]);
    go      = can && ((pend[0] && ch_en[0]) || (pend[1] && ch_en[1]));
    cmask   = sel ? M1 : M0;
    rise_ev = data & ~snap & en_mask & rise_sel & cmask;
    fall_ev = ~data & snap & en_mask & fall_sel & cmask;
    evs     = rise_ev | fall_ev;

    snap_nx = snap;
    if (go)     snap_nx = (snap_nx & ~cmask) | (data & cmask);
    if (arm[0]) snap_nx = (snap_nx & ~M0) | (data & M0);
    if (arm[1]) snap_nx = (snap_nx & ~M1) | (data & M1);

    pend_nx = pend;
    if (go) pend_nx[sel] = 1'b0;
    pend_nx = (pend_nx | chg) & ~arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      snap     <= '0;
      ev_valid <= 1'b0;
      ev_vec   <= '0;
      ev_chan  <= 1'b0;
    end else begin
      pend <= pend_nx;
      snap <= snap_nx;
      if (can) begin
        ev_valid <= go && (|evs);
        if (go && (|evs)) begin
          ev_vec  <= evs;
          ev_chan <= sel;
        end
      end
    end
  end

  // R9: a stalled beat stays put
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_vec) && $stable(ev_chan)));
  // R10: no empty beat is ever presented
  p_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_vec != '0));
  // R7: a beat carries bits of its own channel only
  p_chan_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ((ev_vec & (ev_chan ? M0 : M1)) == '0));
endmodule

// File: rtl/pin_edge_events.sv
module pin_edge_events #(
  parameter int W1 = 5,
  parameter int W2 = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_valid,
  input  logic [$clog2(W1+W2)-1:0]   cfg_pin,
  input  logic [1:0]                 cfg_type,
  output logic                       cfg_err,
  input  logic                       en_valid,
  input  logic [$clog2(W1+W2)-1:0]   en_pin,
  input  logic                       en_set,
  input  logic [W1-1:0]              ch1_data,
  input  logic [W2-1:0]              ch2_data,
  input  logic [1:0]                 chg,
  output logic [1:0]                 ch_en,
  output logic                       ev_valid,
  input  logic                       ev_ready,
  output logic [W1+W2-1:0]           ev_vec,
  output logic                       ev_chan
);
  localparam int NP = W1 + W2;
  localparam int IW = $clog2(NP);

  logic [NP-1:0] rise_sel, fall_sel, en_mask, data;
  logic [1:0]    arm;

  assign data = {ch2_data, ch1_data};

  eev_trig_cfg #(.NP(NP), .IW(IW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_pin(cfg_pin),
    .cfg_type(cfg_type), .cfg_err(cfg_err), .rise_sel(rise_sel), .fall_sel(fall_sel)
  );

  eev_pin_enable #(.W1(W1), .W2(W2), .IW(IW)) u_en (
    .clk(clk), .rst_n(rst_n), .en_valid(en_valid), .en_pin(en_pin), .en_set(en_set),
    .en_mask(en_mask), .ch_en(ch_en), .arm(arm)
  );

  eev_evaluator #(.W1(W1), .W2(W2)) u_eval (
    .clk(clk), .rst_n(rst_n), .data(data), .chg(chg), .ch_en(ch_en), .arm(arm),
    .en_mask(en_mask), .rise_sel(rise_sel), .fall_sel(fall_sel),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_vec(ev_vec), .ev_chan(ev_chan)
  );
endmodule

// File: tb/pin_edge_events_tb.sv
module pin_edge_events_tb;
  localparam int W1 = 5;
  localparam int W2 = 7;
  localparam int NP = W1 + W2;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0, en_valid = 1'b0, en_set = 1'b0, ev_ready = 1'b1;
  logic [IW-1:0] cfg_pin = '0, en_pin = '0;
  logic [1:0]    cfg_type = '0, chg = '0;
  logic [W1-1:0] ch1_data = '0;
  logic [W2-1:0] ch2_data = '0;
  logic          cfg_err, ev_valid, ev_chan;
  logic [1:0]    ch_en;
  logic [NP-1:0] ev_vec;

  int  checks = 0, errors = 0;
  bit  done = 0;

  pin_edge_events #(.W1(W1), .W2(W2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_pin(cfg_pin), .cfg_type(cfg_type),
    .cfg_err(cfg_err), .en_valid(en_valid), .en_pin(en_pin), .en_set(en_set),
    .ch1_data(ch1_data), .ch2_data(ch2_data), .chg(chg), .ch_en(ch_en),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_vec(ev_vec), .ev_chan(ev_chan)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [NP-1:0] m_en, m_rs, m_fs, m_snap, m_vec;
  logic [1:0]    m_pend, m_chen;
  logic          m_valid, m_chan, m_err;

  function automatic int chan_of(input int b);
    return (b < W1) ? 0 : 1;
  endfunction

  function automatic bit any_on(input logic [NP-1:0] v, input int c);
    for (int b = 0; b < NP; b++) if (chan_of(b) == c && v[b]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    logic [NP-1:0] d, ev, newen;
    int s;
    bit can;
    bit [1:0] armv;
    if (!rst_n) begin
      m_en = '0; m_rs = '0; m_fs = '0; m_snap = '0; m_vec = '0;
      m_pend = '0; m_chen = '0; m_valid = 0; m_chan = 0; m_err = 0;
    end else begin
      d   = {ch2_data, ch1_data};
      can = !m_valid || ev_ready;
      s   = -1;
      if (m_pend[0] && m_chen[0]) s = 0;
      else if (m_pend[1] && m_chen[1]) s = 1;
      ev = '0;
      if (can && s >= 0)
        for (int b = 0; b < NP; b++)
          if (chan_of(b) == s && m_en[b]) begin
            if (d[b] && !m_snap[b] && m_rs[b]) ev[b] = 1'b1;
            if (!d[b] && m_snap[b] && m_fs[b]) ev[b] = 1'b1;
          end
      armv  = '0;
      newen = m_en;
      if (en_valid && int'(en_pin) < NP) begin
        if (en_set && !any_on(m_en, chan_of(int'(en_pin)))) armv[chan_of(int'(en_pin))] = 1'b1;
        newen[en_pin] = en_set;
      end
      for (int b = 0; b < NP; b++) begin
        if (can && s >= 0 && chan_of(b) == s) m_snap[b] = d[b];
        if (armv[chan_of(b)]) m_snap[b] = d[b];
      end
      if (can && s >= 0) m_pend[s] = 1'b0;
      m_pend = (m_pend | chg) & ~armv;
      if (can) begin
        m_valid = (ev != '0);
        if (ev != '0) begin m_vec = ev; m_chan = s[0]; end
      end
      m_en = newen;
      for (int c = 0; c < 2; c++) m_chen[c] = any_on(newen, c);
      m_err = cfg_valid && cfg_type == 2'b00;
      if (cfg_valid && int'(cfg_pin) < NP)
        case (cfg_type)
          2'b01: begin m_rs[cfg_pin] = 1'b1; m_fs[cfg_pin] = 1'b0; end
          2'b10: begin m_rs[cfg_pin] = 1'b0; m_fs[cfg_pin] = 1'b1; end
          2'b11: begin m_rs[cfg_pin] = 1'b1; m_fs[cfg_pin] = 1'b1; end
          default: ;
        endcase
    end
  end

  // compare on every clock, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done) begin
      chk(ev_valid === m_valid, "R9 model ev_valid", 32'(ev_valid), 32'(m_valid));
      if (m_valid) begin
        chk(ev_vec === m_vec, "R3 model ev_vec", 32'(ev_vec), 32'(m_vec));
        chk(ev_chan === m_chan, "R8 model ev_chan", 32'(ev_chan), 32'(m_chan));
      end
      chk(ch_en === m_chen, "R5 R6 model ch_en", 32'(ch_en), 32'(m_chen));
      chk(cfg_err === m_err, "R4 model cfg_err", 32'(cfg_err), 32'(m_err));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfg(input int pin, input logic [1:0] t);
    @(negedge clk); cfg_valid = 1; cfg_pin = IW'(pin); cfg_type = t;
    @(negedge clk); cfg_valid = 0;
  endtask

  task automatic en(input int pin, input bit s);
    @(negedge clk); en_valid = 1; en_pin = IW'(pin); en_set = s;
    @(negedge clk); en_valid = 0;
  endtask

  task automatic change(input logic [W1-1:0] d1, input logic [W2-1:0] d2, input logic [1:0] c);
    @(negedge clk); ch1_data = d1; ch2_data = d2; chg = c;
    @(negedge clk); chg = 0;
  endtask

  task automatic setdata(input logic [W1-1:0] d1, input logic [W2-1:0] d2);
    @(negedge clk); ch1_data = d1; ch2_data = d2;
  endtask

  task automatic wait_beat(input logic [NP-1:0] v, input bit c, input string tag);
    bit seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      seen = ev_valid;
    end
    chk(seen, {tag, " beat present"}, 32'(seen), 32'd1);
    chk(ev_vec === v, {tag, " vector"}, 32'(ev_vec), 32'(v));
    chk(ev_chan === c, {tag, " channel"}, 32'(ev_chan), 32'(c));
  endtask

  task automatic no_beat(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ev_valid) seen = 1;
    end
    chk(!seen, tag, 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(ev_valid == 0 && ch_en == 0 && cfg_err == 0, "R11 reset outputs",
        {29'd0, ev_valid, ch_en}, 32'd0);
    rst_n = 1;

    cfg(1, 2'b01); cfg(2, 2'b10); cfg(3, 2'b11); cfg(7, 2'b01); cfg(11, 2'b11);
    cfg(4, 2'b00);
    chk(cfg_err === 1'b1, "R4 level code flagged", 32'(cfg_err), 32'd1);
    cfg(2, 2'b00);            // R4: must not disturb pin 2 falling select
    cfg(13, 2'b01);           // R7: out of range, no effect

    en(13, 1);
    chk(ch_en === 2'b00, "R7 out-of-range enable ignored", 32'(ch_en), 32'd0);
    en(1, 1);
    chk(ch_en === 2'b01, "R5 first pin turns channel on", 32'(ch_en), 32'd1);
    en(2, 1); en(3, 1);

    change(5'b00110, '0, 2'b01); wait_beat(12'h002, 0, "R1 rising pin1");
    change(5'b00000, '0, 2'b01); wait_beat(12'h004, 0, "R2 falling pin2 kept after rejected code");
    change(5'b01000, '0, 2'b01); wait_beat(12'h008, 0, "R3 both-edge pin3 rise");
    change(5'b00000, '0, 2'b01); wait_beat(12'h008, 0, "R3 both-edge pin3 fall");

    setdata(5'b00010, '0); setdata(5'b00000, '0);
    change(5'b00000, '0, 2'b01); no_beat(6, "R3 snapshot not previous cycle");
    change(5'b10000, '0, 2'b01); no_beat(6, "R10 disabled pin no beat");
    change(5'b00000, '0, 2'b01); no_beat(4, "R10 quiet eval");

    en(7, 1);
    chk(ch_en === 2'b11, "R5 channel 2 on", 32'(ch_en), 32'd3);
    en(11, 1);
    change(5'b00010, 7'b0000100, 2'b11);
    wait_beat(12'h002, 0, "R8 channel 1 first");
    wait_beat(12'h080, 1, "R7 channel 2 offset");

    @(negedge clk); ev_ready = 0;
    change(5'b01010, 7'b0000100, 2'b01);
    change(5'b01010, 7'b1000100, 2'b10);
    wait_beat(12'h008, 0, "R9 stalled beat");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ev_valid && ev_vec == 12'h008 && ev_chan == 0, "R9 hold while not ready",
          32'(ev_vec), 32'h008);
    end
    ev_ready = 1;
    wait_beat(12'h800, 1, "R9 R8 pending channel after release");

    change(5'b01000, 7'b1000100, 2'b01); no_beat(4, "R10 no qualifying edge");
    en(1, 0); en(2, 0);
    chk(ch_en === 2'b11, "R6 channel stays on with pins left", 32'(ch_en), 32'd3);
    en(3, 0);
    chk(ch_en === 2'b10, "R6 last pin cleared", 32'(ch_en), 32'd2);

    setdata(5'b00010, 7'b1000100);
    change(5'b00010, 7'b1000100, 2'b01);   // R8: pending latched while off
    en(1, 1);
    no_beat(6, "R5 stale pending discarded");
    change(5'b00010, 7'b1000100, 2'b01);
    no_beat(6, "R5 snapshot reloaded");
    change(5'b00000, 7'b1000100, 2'b01); no_beat(3, "R10 rise-only pin falls");
    change(5'b00010, 7'b1000100, 2'b01); wait_beat(12'h002, 0, "R1 after re-enable");

    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      cfg_valid = ($urandom % 8) == 0;
      cfg_pin   = IW'($urandom);
      cfg_type  = 2'($urandom);
      en_valid  = ($urandom % 5) == 0;
      en_pin    = IW'($urandom);
      en_set    = ($urandom % 3) != 0;
      ch1_data  = W1'($urandom);
      ch2_data  = W2'($urandom);
      chg       = 2'($urandom % 4);
      ev_ready  = ($urandom % 4) != 0;
    end
    @(negedge clk);
    cfg_valid = 0; en_valid = 0; chg = 0; ev_ready = 1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule